// File: doc/BRIEF.md
# Coarse-Stage Successive-Approximation Controller with Segmented Switch Drive

This block sequences the binary search of the coarse first stage of a two-stage pipelined successive-approximation converter. A one-clock sampling pulse on `start_i` clears and presets the search state. The block then tries one bit per clock, starting with the most significant of its seven bits. Each trial first sets the bit under test to 1. The comparator decision on `cmp_i` in that cycle then decides whether the bit stays set.

The tentative code drives the capacitor array as it is built up, and it goes out in segmented form. The three upper bits are decoded as they change into seven unary thermometer lines. The four lower bits go out as plain binary switch controls. When the search ends, the block publishes the resolved code, gives a one-clock completion pulse, and one step later raises a flag. That flag tells the following gain stage that the residue on the array is valid. A new sampling pulse that arrives during a search abandons that search and starts again from the top bit.

Top module: `sar_seg_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the outputs `therm_o`, `bin_o`, `code_o`, `done_o` and `res_ready_o` are all 0 until the first start.
- R2: In the k-th cycle after the edge that samples `start_i` high (k = 1..7), the code on the array is formed from three parts. The bits already decided are kept. Bit 7-k is set to 1. All bits below it are 0. The bits are numbered 6 (most significant) down to 0.
- R3: A trial keeps its bit when `cmp_i` is 1 in that trial's cycle, meaning the input is at or above the array level. The bit is cleared when `cmp_i` is 0. With an ideal comparator, the final code equals the analog value.
- R4: `therm_o[k]` is 1 exactly when code bits [6:4], read as an unsigned value, are greater than k. `bin_o` carries code bits [3:0].
- R5: `done_o` is high for exactly one cycle, in the 8th cycle after the start edge. This is the cycle after the bit-0 trial.
- R6: `code_o` takes the resolved code in the cycle in which `done_o` is high. At all other times it holds its value, including across later starts, until the next completion.
- R7: `res_ready_o` rises one clock after `done_o`, which is 8 edges after the start edge. It stays high until the edge that samples the next start, and that edge clears it.
- R8: When `start_i` is high during a search, that search is abandoned without any `done_o` pulse. The next cycle shows the first trial of a new search, with only bit 6 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-clock sampling pulse that begins a search |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above the array level |
| therm_o | output | 7 | Unary thermometer lines for code bits [6:4] |
| bin_o | output | 4 | Binary switch lines for code bits [3:0] |
| code_o | output | 7 | Resolved code, held between completions |
| done_o | output | 1 | One-clock completion pulse |
| res_ready_o | output | 1 | Residue valid for the gain stage |

## Verification
Counting from the edge that samples the start pulse, the trial pattern for bit 7-k shows on the switch lines k edges later. `done_o` and `code_o` change after 8 edges, and `res_ready_o` rises after 9 edges. The bench drives inputs and samples outputs only on falling clock edges. It compares each cycle against the pattern expected for that exact count. In each trial cycle it also feeds back an ideal comparator decision, computed from the lines it has just observed. An abort is checked in the cycle that follows the second start, and `done_o` is watched for staying low.

// File: rtl/sar_seg_pkg.sv
package sar_seg_pkg;

   // number of unary lines needed for a segment of seg_bits binary bits
   function automatic int therm_width(input int seg_bits);
      return (1 << seg_bits) - 1;
   endfunction

endpackage

// File: rtl/sar_seg_seq.sv
module sar_seg_seq #(
   parameter int NBITS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cmp_i,
   output logic [NBITS-1:0] dac_o,
   output logic             last_o
);
   localparam logic [NBITS-1:0] TOP_ONE = NBITS'(1) << (NBITS - 1);

   logic [NBITS-1:0] trial_q;   // one-hot: bit under test
   logic [NBITS-1:0] dac_q;     // decision row
   logic [NBITS-1:0] dac_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       trial_q <= '0;
      else if (start_i) trial_q <= TOP_ONE;
      else              trial_q <= trial_q >> 1;
   end

   for (genvar i = 0; i < NBITS; i++) begin : g_row
      if (i == NBITS - 1) begin : g_top
         assign dac_d[i] = trial_q[i] ? cmp_i : dac_q[i];
      end else begin : g_low
         assign dac_d[i] = trial_q[i]   ? cmp_i :
                           trial_q[i+1] ? 1'b1  : dac_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dac_q <= '0;
      else if (start_i) dac_q <= TOP_ONE;
      else              dac_q <= dac_d;
   end

   assign dac_o  = dac_q;
   assign last_o = trial_q[0];
endmodule

// File: rtl/sar_seg_therm.sv
module sar_seg_therm #(
   parameter int SEG_BITS = 3,
   parameter int TW       = 7
) (
   input  logic [SEG_BITS-1:0] seg_i,
   output logic [TW-1:0]       therm_o
);
   for (genvar k = 0; k < TW; k++) begin : g_line
      assign therm_o[k] = (int'(seg_i) > k);
   end
endmodule

// File: rtl/sar_seg_ctrl.sv
module sar_seg_ctrl #(
   parameter int NBITS    = 7,
   parameter int SEG_BITS = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic                         cmp_i,
   output logic [(1<<SEG_BITS)-2:0]     therm_o,
   output logic [NBITS-SEG_BITS-1:0]    bin_o,
   output logic [NBITS-1:0]             code_o,
   output logic                         done_o,
   output logic                         res_ready_o
);
   localparam int TW = sar_seg_pkg::therm_width(SEG_BITS);
   localparam int BW = NBITS - SEG_BITS;

   if (NBITS < 2) begin : g_bad_nbits
      $error("sar_seg_ctrl: NBITS must be at least 2");
   end
   if (SEG_BITS < 1 || SEG_BITS >= NBITS) begin : g_bad_seg
      $error("sar_seg_ctrl: SEG_BITS must lie in 1..NBITS-1");
   end

   logic [NBITS-1:0] dac;
   logic             last;
   logic             done_q, ready_q;
   logic [NBITS-1:0] code_q;

   sar_seg_seq #(.NBITS(NBITS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .cmp_i   (cmp_i),
      .dac_o   (dac),
      .last_o  (last)
   );

   sar_seg_therm #(.SEG_BITS(SEG_BITS), .TW(TW)) u_therm (
      .seg_i   (dac[NBITS-1:BW]),
      .therm_o (therm_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         ready_q <= 1'b0;
         code_q  <= '0;
      end else begin
         done_q <= last && !start_i;
         if (start_i)     ready_q <= 1'b0;
         else if (done_q) ready_q <= 1'b1;
         if (last && !start_i) code_q <= {dac[NBITS-1:1], cmp_i};
      end
   end

   assign bin_o       = dac[BW-1:0];
   assign code_o      = code_q;
   assign done_o      = done_q;
   assign res_ready_o = ready_q;
endmodule

// File: rtl/sar_seg_ctrl_chk.sv
module sar_seg_ctrl_chk #(
   parameter int NBITS    = 7,
   parameter int SEG_BITS = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      start_i,
   input logic [(1<<SEG_BITS)-2:0]  therm_o,
   input logic [NBITS-SEG_BITS-1:0] bin_o,
   input logic [NBITS-1:0]          code_o,
   input logic                      done_o,
   input logic                      res_ready_o
);
   localparam int TW = (1 << SEG_BITS) - 1;
   localparam logic [TW-1:0] FIRST_THERM = TW'((1 << (1 << (SEG_BITS - 1))) - 1);

   // R2
   first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (therm_o == FIRST_THERM && bin_o == '0));

   // R4
   therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (therm_o & (therm_o + 1'b1)) == '0);

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_o) |-> done_o);

   // R7
   ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> res_ready_o);

   // R7
   ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !res_ready_o);

   // R8
   abort_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !done_o);
endmodule

bind sar_seg_ctrl sar_seg_ctrl_chk #(.NBITS(NBITS), .SEG_BITS(SEG_BITS)) u_chk (.*);

// File: tb/sar_seg_ctrl_bench.sv
module sar_seg_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       cmp_i = 1'b0;
   logic [6:0] therm_o;
   logic [3:0] bin_o;
   logic [6:0] code_o;
   logic       done_o;
   logic       res_ready_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   sar_seg_ctrl u_sar_seg_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
      .therm_o(therm_o), .bin_o(bin_o), .code_o(code_o),
      .done_o(done_o), .res_ready_o(res_ready_o)
   );

   // analog value and expected code (ideal comparator)
   typedef struct packed { logic [6:0] ain; logic [6:0] exp; } vec_t;
   localparam vec_t VEC [10] = '{
      '{7'd0,   7'd0},   '{7'd127, 7'd127}, '{7'd64, 7'd64}, '{7'd63, 7'd63},
      '{7'd1,   7'd1},   '{7'd85,  7'd85},  '{7'd42, 7'd42}, '{7'd100, 7'd100},
      '{7'd7,   7'd7},   '{7'd120, 7'd120}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [6:0] therm_of(input logic [2:0] v);
      logic [6:0] t;
      for (int k = 0; k < 7; k++) t[k] = (int'(v) > k);
      return t;
   endfunction

   // abort_at: leave the search in that trial cycle (0 = run to the end)
   task automatic run_conv(input logic [6:0] ain, input logic [6:0] exp,
                           input int abort_at, input string tag);
      int tent;
      logic [6:0] dac_seen;
      @(negedge clk) start_i = 1'b1; cmp_i = 1'b0;
      @(negedge clk) start_i = 1'b0;
      for (int k = 1; k <= 7; k++) begin
         tent = (int'(ain) & ~((1 << (8 - k)) - 1) & 8'h7f) | (1 << (7 - k));
         chk({tag, " therm"}, int'(therm_o), int'(therm_of(tent[6:4])));   // R4
         chk({tag, " bin"}, int'(bin_o), tent & 4'hf);
         chk("R5 no early done", int'(done_o), 0);
         if (k == abort_at) return;
         dac_seen = {3'($countones(therm_o)), bin_o};
         cmp_i = (ain >= dac_seen);
         @(negedge clk);
      end
      cmp_i = 1'b0;
      chk("R5 done", int'(done_o), 1);
      chk("R6 code", int'(code_o), int'(exp));
      chk("R3 final bin", int'(bin_o), int'(exp[3:0]));
      chk("R3 final therm", int'(therm_o), int'(therm_of(exp[6:4])));
      chk("R7 not yet", int'(res_ready_o), 0);
      @(negedge clk);
      chk("R5 done width", int'(done_o), 0);
      chk("R7 ready", int'(res_ready_o), 1);
      chk("R6 code kept", int'(code_o), int'(exp));
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [6:0] seed;
      repeat (3) @(negedge clk);
      chk("R1 therm", int'(therm_o), 0);
      chk("R1 code", int'(code_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 bin", int'(bin_o), 0);
      chk("R1 done", int'(done_o), 0);
      chk("R1 ready", int'(res_ready_o), 0);

      foreach (VEC[i]) run_conv(VEC[i].ain, VEC[i].exp, 0, "R2");

      seed = 7'd37;
      for (int n = 0; n < 20; n++) begin
         seed = 7'(seed * 7'd29 + 7'd11);
         run_conv(seed, seed, 0, "R2 lcg");
      end

      // hold: code, lines and ready stay put while comparator toggles (R6, R7)
      run_conv(7'd93, 7'd93, 0, "R2");
      for (int n = 0; n < 5; n++) begin
         @(negedge clk) cmp_i = n[0];
         chk("R6 hold code", int'(code_o), 93);
         chk("R7 hold ready", int'(res_ready_o), 1);
         chk("R3 hold bin", int'(bin_o), 93 & 15);
      end
      cmp_i = 1'b0;

      // abort mid-search, then a clean restart from bit 6 (R8)
      run_conv(7'd17, 7'd17, 3, "R8 first");
      run_conv(7'd110, 7'd110, 0, "R8 restart");
      chk("R6 code after abort", int'(code_o), 110);

      // start clears ready on the next cycle, code kept (R7, R6)
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      chk("R7 cleared", int'(res_ready_o), 0);
      chk("R6 kept over start", int'(code_o), 110);

      // reset in mid-search returns everything to 0 (R1)
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid reset therm", int'(therm_o), 0);
      chk("R1 mid reset code", int'(code_o), 0);
      rst_n = 1'b1;
      repeat (9) @(negedge clk);
      chk("R1 no done after reset", int'(done_o), 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule